// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Holding Buffer

This block turns an idle-high asynchronous serial line into parallel characters. A falling edge on the line begins a candidate start bit. The block confirms the start bit half a bit period later. It then takes the data bits, an optional parity bit and the first stop bit, one sample per bit period. A shared oversampling tick paces every sample, and a bit period is sixteen ticks. Each completed character goes into a holding buffer, together with its framing and parity status. The host reads the buffer there.

The host sets the character length (5 to 8 bits), the parity mode and the stop-bit count, then enables reception. The receive-complete flag tells the host that a character is waiting, and a read strobe clears the flag. If the host does not read in time, the next character replaces the held one. With two stop bits configured, the character is delivered as soon as the first stop bit is sampled. The second stop slot is then waited out and never checked.

Top module: `uart_rx_buffered`

## Requirements
- R1: While `rx_en` is 0 the line is ignored: no character is delivered, `rx_done` does not rise and `rd_data` keeps its value.
- R2: A low pulse shorter than half a bit period (line high again at the 8th tick after the falling edge) does not start reception and delivers nothing.
- R3: Data bits are sampled once per bit period at mid-bit and are assembled least significant bit first, so the first bit after the start bit lands in `rd_data[0]`.
- R4: `cfg_len` selects the character length as 5 + `cfg_len` (0 gives 5 bits, 3 gives 8 bits), and bits of `rd_data` at and above that length read 0.
- R5: With `cfg_par_en` = 1, one parity bit follows the last data bit. With `cfg_par_odd` = 0 the data bits plus the parity bit must hold an even number of ones, and with 1 an odd number. A mismatch sets `parity_err` for that character. With `cfg_par_en` = 0, `parity_err` is 0.
- R6: A first stop bit sampled low sets `frame_err` for that character, and the character is still delivered.
- R7: With `cfg_two_stop` = 1 the character is delivered by the end of the first stop bit. The second stop slot is not checked, and a low level there neither sets `frame_err` nor starts a new character.
- R8: `rx_done` rises when a character enters the buffer, and it falls after a `host_rd` strobe while `rd_data` keeps the character.
- R9: A character that arrives before the host reads the buffer replaces the buffered data and flags, and `rx_done` stays 1.
- R10: After reset, `rd_data` is 0 and `rx_done`, `frame_err` and `parity_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_len | input | 2 | Character length code (5 + value) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | Two stop bits on the line |
| host_rd | input | 1 | Read strobe that clears `rx_done` |
| rd_data | output | 8 | Buffered character, right-aligned |
| rx_done | output | 1 | Character waiting in the buffer |
| frame_err | output | 1 | Buffered character had a low stop bit |
| parity_err | output | 1 | Buffered character failed parity |

## Verification
The line passes through a two-flop synchronizer. The stop-bit sample then registers the character in the sequencer, and the buffer registers it once more. A result is therefore due about four clock cycles after the mid-point of the first stop bit, which is roughly half a bit period before that stop slot ends. The bench holds each bit for exactly one bit period (64 clocks), so it checks outputs at the end of the first stop slot and never near the sampling instant. Read-strobe effects are checked one falling edge after the strobe. No-effect cases (disabled receiver, short glitch, the second stop slot) are judged several bit periods later, once any wrongly started character would have finished.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the serial receiver: sequencer states and the
// character-length decode. Assumes at most 8 data bits per character.
package uart_rx_pkg;

    localparam int unsigned CHAR_W  = 8;   // widest character
    localparam int unsigned MIN_LEN = 5;   // length for code 0

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_HOLD
    } rx_state_t;

    // Map the 2-bit length code onto a bit count (5..8).
    function automatic logic [3:0] decode_len(input logic [1:0] code);
        return 4'(MIN_LEN) + {2'b00, code};
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
`timescale 1ns/1ps
// Brings the asynchronous serial line into the clock domain and flags a
// high-to-low transition. Assumes STAGES >= 2. Resets to the idle (high)
// level so that no edge is reported out of reset.
module rx_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic line,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              line_prev;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], rxd};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_prev <= 1'b1;
        else        line_prev <= chain[STAGES-1];
    end

    assign line = chain[STAGES-1];
    assign fall = line_prev & ~line;

endmodule

// File: rtl/rx_frame_fsm.sv
`timescale 1ns/1ps
// Frame sequencer: validates the start bit at mid-bit, samples data,
// optional parity and the first stop bit once per bit period, then emits a
// one-cycle load with the character and its status. A second stop slot is
// waited out unchecked. Assumes os_tick is a single-cycle pulse.
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int unsigned OS_RATE = 16,
    parameter int unsigned DATA_W  = CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              os_tick,
    input  logic              line,
    input  logic              fall,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    output logic              load,
    output logic [DATA_W-1:0] char_data,
    output logic              char_ferr,
    output logic              char_perr
);

    localparam int unsigned CNT_W = $clog2(OS_RATE);
    localparam int unsigned IDX_W = $clog2(DATA_W) + 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OS_RATE - 1);

    rx_state_t          state;
    logic [CNT_W-1:0]   tcnt;
    logic [IDX_W-1:0]   bidx;
    logic [IDX_W-1:0]   len_q;
    logic               par_en_q;
    logic               par_odd_q;
    logic               two_stop_q;
    logic [DATA_W-1:0]  shreg;
    logic               par_acc;
    logic               perr_q;
    logic               bit_due;

    // A sample is due on the tick that closes the current bit period.
    assign bit_due = os_tick && (tcnt == BIT_LAST);

    // Sequencer: frame progress, sampling, and character hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            tcnt       <= '0;
            bidx       <= '0;
            len_q      <= '0;
            par_en_q   <= 1'b0;
            par_odd_q  <= 1'b0;
            two_stop_q <= 1'b0;
            shreg      <= '0;
            par_acc    <= 1'b0;
            perr_q     <= 1'b0;
            load       <= 1'b0;
            char_data  <= '0;
            char_ferr  <= 1'b0;
            char_perr  <= 1'b0;
        end else begin
            load <= 1'b0;
            if (!rx_en) begin
                state <= RX_IDLE;
                tcnt  <= '0;
            end else begin
                case (state)
                    RX_IDLE: begin
                        if (fall) begin
                            state <= RX_START;
                            tcnt  <= '0;
                        end
                    end
                    RX_START: begin
                        if (os_tick) begin
                            if (tcnt == HALF_LAST) begin
                                tcnt <= '0;
                                if (!line) begin
                                    state      <= RX_DATA;
                                    bidx       <= '0;
                                    shreg      <= '0;
                                    par_acc    <= 1'b0;
                                    perr_q     <= 1'b0;
                                    len_q      <= IDX_W'(decode_len(cfg_len));
                                    par_en_q   <= cfg_par_en;
                                    par_odd_q  <= cfg_par_odd;
                                    two_stop_q <= cfg_two_stop;
                                end else begin
                                    state <= RX_IDLE;
                                end
                            end else begin
                                tcnt <= tcnt + 1'b1;
                            end
                        end
                    end
                    RX_DATA: begin
                        if (os_tick) tcnt <= tcnt + 1'b1;
                        if (bit_due) begin
                            shreg[bidx[IDX_W-2:0]] <= line;
                            par_acc <= par_acc ^ line;
                            if (bidx == len_q - 1'b1) begin
                                state <= par_en_q ? RX_PARITY : RX_STOP;
                            end else begin
                                bidx <= bidx + 1'b1;
                            end
                        end
                    end
                    RX_PARITY: begin
                        if (os_tick) tcnt <= tcnt + 1'b1;
                        if (bit_due) begin
                            perr_q <= par_acc ^ line ^ par_odd_q;
                            state  <= RX_STOP;
                        end
                    end
                    RX_STOP: begin
                        if (os_tick) tcnt <= tcnt + 1'b1;
                        if (bit_due) begin
                            load      <= 1'b1;
                            char_data <= shreg;
                            char_ferr <= ~line;
                            char_perr <= perr_q;
                            state     <= two_stop_q ? RX_HOLD : RX_IDLE;
                        end
                    end
                    RX_HOLD: begin
                        if (os_tick) tcnt <= tcnt + 1'b1;
                        if (bit_due) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R1: a cleared enable parks the sequencer in idle.
    p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state == RX_IDLE);

    // R2: data sampling is entered only after a low mid-start sample.
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA && $past(state) == RX_START) |-> !$past(line));

    // R4: no delivered bit lies above the latched length.
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (char_data >> len_q) == '0);

    // R5: without parity, the delivered parity status is clear.
    p_no_par_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !par_en_q) |-> !char_perr);

endmodule

// File: rtl/rx_buffer.sv
`timescale 1ns/1ps
// Receive holding buffer: captures a character with its status on load and
// keeps a completion flag that a host read clears. A load in the same cycle
// as a read wins, so a fresh character is never reported as consumed.
module rx_buffer #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_ferr,
    input  logic              in_perr,
    input  logic              host_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_done,
    output logic              frame_err,
    output logic              parity_err
);

    // Capture the character and its status; newer data overwrites older.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data    <= '0;
            frame_err  <= 1'b0;
            parity_err <= 1'b0;
        end else if (load) begin
            rd_data    <= in_data;
            frame_err  <= in_ferr;
            parity_err <= in_perr;
        end
    end

    // Completion flag: set by a load, cleared by a host read.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_done <= 1'b0;
        else if (load)    rx_done <= 1'b1;
        else if (host_rd) rx_done <= 1'b0;
    end

    // R8: a load always leaves the flag raised.
    p_done_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> rx_done);

    // R8: a read without a concurrent load drops the flag.
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !load) |=> !rx_done);

    // R1: held data only changes through a load.
    p_data_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rd_data));

    // R6: the framing status travels with its character.
    p_ferr_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> frame_err == $past(in_ferr));

endmodule

// File: rtl/uart_rx_buffered.sv
`timescale 1ns/1ps
// Top of the asynchronous serial receiver: synchronizer, frame sequencer and
// holding buffer. Assumes os_tick runs at OS_RATE times the bit rate and is
// synchronous to clk.
module uart_rx_buffered
    import uart_rx_pkg::*;
#(
    parameter int unsigned OS_RATE     = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              os_tick,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              host_rd,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rx_done,
    output logic              frame_err,
    output logic              parity_err
);

    logic              line_s;
    logic              line_fall;
    logic              chr_load;
    logic [CHAR_W-1:0] chr_data;
    logic              chr_ferr;
    logic              chr_perr;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rxd   (rxd),
        .line  (line_s),
        .fall  (line_fall)
    );

    rx_frame_fsm #(.OS_RATE(OS_RATE), .DATA_W(CHAR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_en        (rx_en),
        .os_tick      (os_tick),
        .line         (line_s),
        .fall         (line_fall),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .load         (chr_load),
        .char_data    (chr_data),
        .char_ferr    (chr_ferr),
        .char_perr    (chr_perr)
    );

    rx_buffer #(.DATA_W(CHAR_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (chr_load),
        .in_data    (chr_data),
        .in_ferr    (chr_ferr),
        .in_perr    (chr_perr),
        .host_rd    (host_rd),
        .rd_data    (rd_data),
        .rx_done    (rx_done),
        .frame_err  (frame_err),
        .parity_err (parity_err)
    );

endmodule

// File: tb/uart_rx_buffered_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module uart_rx_buffered_bench;

    localparam int TICK_DIV = 4;              // clocks per oversampling tick
    localparam int BIT_CLKS = 16 * TICK_DIV;  // clocks per bit period
    localparam int WDOG     = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       os_tick;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] rd_data;
    logic       rx_done;
    logic       frame_err;
    logic       parity_err;

    int n_chk  = 0;
    int n_fail = 0;
    int tick_cnt = 0;

    always #2 clk = ~clk;

    always @(posedge clk) tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    assign os_tick = (tick_cnt == TICK_DIV - 1);

    uart_rx_buffered u_uart_rx_buffered (
        .clk          (clk),
        .rst_n        (rst_n),
        .rxd          (rxd),
        .rx_en        (rx_en),
        .os_tick      (os_tick),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .host_rd      (host_rd),
        .rd_data      (rd_data),
        .rx_done      (rx_done),
        .frame_err    (frame_err),
        .parity_err   (parity_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic ones_odd(input logic [7:0] d, input int n);
        logic p = 1'b0;
        for (int i = 0; i < n; i++) p = p ^ d[i];
        return p;
    endfunction

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic idle_bits(input int n);
        repeat (n) drive_bit(1'b1);
    endtask

    // Start, data LSB first, optional parity, first stop; line left high.
    task automatic send_frame(input logic [7:0] d, input int n, input logic pen,
                              input logic pbit, input logic stop1);
        @(negedge clk);
        cfg_len    = 2'(n - 5);
        cfg_par_en = pen;
        drive_bit(1'b0);
        for (int i = 0; i < n; i++) drive_bit(d[i]);
        if (pen) drive_bit(pbit);
        drive_bit(stop1);
        rxd = 1'b1;
    endtask

    task automatic host_read();
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 data", rd_data, 0);
        chk("R10 done", rx_done, 0);
        chk("R10 ferr", frame_err, 0);
        chk("R10 perr", parity_err, 0);
    endtask

    task automatic t_basic();
        send_frame(8'hA5, 8, 1'b0, 1'b0, 1'b1);
        chk("R3 data A5", rd_data, 8'hA5);
        chk("R8 done set", rx_done, 1);
        chk("R6 no ferr", frame_err, 0);
        chk("R5 no perr", parity_err, 0);
        idle_bits(1);
        host_read();
        chk("R8 done cleared", rx_done, 0);
        chk("R8 data kept", rd_data, 8'hA5);
        send_frame(8'h01, 8, 1'b0, 1'b0, 1'b1);
        chk("R3 lsb first", rd_data, 8'h01);
        idle_bits(1);
        host_read();
    endtask

    task automatic t_lengths();
        for (int n = 5; n <= 7; n++) begin
            send_frame(8'hFF, n, 1'b0, 1'b0, 1'b1);
            chk("R4 all ones", rd_data, (32'd1 << n) - 1);
            idle_bits(1);
            host_read();
        end
        send_frame(8'hF5, 5, 1'b0, 1'b0, 1'b1);
        chk("R4 5-bit pattern", rd_data, 8'h15);
        idle_bits(1);
        host_read();
    endtask

    task automatic t_parity();
        logic [7:0] d = 8'h6B;
        cfg_par_odd = 1'b0;
        send_frame(d, 8, 1'b1, ones_odd(d, 8), 1'b1);
        chk("R5 even ok data", rd_data, d);
        chk("R5 even ok", parity_err, 0);
        idle_bits(1); host_read();
        cfg_par_odd = 1'b1;
        send_frame(d, 8, 1'b1, ~ones_odd(d, 8), 1'b1);
        chk("R5 odd ok", parity_err, 0);
        idle_bits(1); host_read();
        send_frame(d, 8, 1'b1, ones_odd(d, 8), 1'b1);
        chk("R5 odd bad", parity_err, 1);
        idle_bits(1); host_read();
        cfg_par_odd = 1'b0;
        send_frame(8'h13, 6, 1'b1, ~ones_odd(8'h13, 6), 1'b1);
        chk("R5 even bad", parity_err, 1);
        chk("R5 even bad data", rd_data, 8'h13);
        idle_bits(1); host_read();
    endtask

    task automatic t_frame_err();
        send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0);
        chk("R6 ferr set", frame_err, 1);
        chk("R6 delivered", rd_data, 8'h3C);
        chk("R6 done", rx_done, 1);
        idle_bits(2); host_read();
        send_frame(8'h3D, 8, 1'b0, 1'b0, 1'b1);
        chk("R6 ferr clears", frame_err, 0);
        idle_bits(1); host_read();
    endtask

    task automatic t_glitch();
        @(negedge clk);
        rxd = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        idle_bits(14);
        chk("R2 glitch no done", rx_done, 0);
        chk("R2 glitch data kept", rd_data, 8'h3D);
    endtask

    task automatic t_disabled();
        rx_en = 1'b0;
        send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b1);
        idle_bits(3);
        chk("R1 disabled no done", rx_done, 0);
        chk("R1 disabled data kept", rd_data, 8'h3D);
        rx_en = 1'b1;
        idle_bits(1);
    endtask

    task automatic t_overwrite();
        send_frame(8'h11, 8, 1'b0, 1'b0, 1'b0);
        idle_bits(1);
        send_frame(8'h22, 8, 1'b0, 1'b0, 1'b1);
        chk("R9 newest data", rd_data, 8'h22);
        chk("R9 flags replaced", frame_err, 0);
        chk("R9 done held", rx_done, 1);
        idle_bits(1); host_read();
    endtask

    task automatic t_two_stop();
        cfg_two_stop = 1'b1;
        send_frame(8'h96, 8, 1'b0, 1'b0, 1'b1);
        chk("R7 done after first stop", rx_done, 1);
        chk("R7 data", rd_data, 8'h96);
        drive_bit(1'b0);      // second stop slot held low
        rxd = 1'b1;
        chk("R7 no ferr", frame_err, 0);
        host_read();
        idle_bits(14);
        chk("R7 no extra char", rx_done, 0);
        cfg_two_stop = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        rx_en = 1'b1;
        idle_bits(1);
        t_basic();
        t_lengths();
        t_parity();
        t_frame_err();
        t_glitch();
        t_disabled();
        t_overwrite();
        t_two_stop();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule